// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Time-Shared DAC

This block is the digital sequencer for an 8-bit successive-approximation analog-to-digital conversion. The block has no converter of its own. It borrows the digital-to-analog converter that normally drives the analog output. A start strobe opens a conversion. The block first runs a track phase for the input sample-and-hold. It then holds the sample and runs one compare step per result bit, starting at the most significant bit. On each step it drives a trial code to the shared DAC and reads a one-bit comparator decision.

While the conversion owns the DAC, the block tells the analog output buffer to freeze its last level. When the conversion ends, the DAC is handed back to the value in the output data register. The finished code goes into a result register and a one-cycle done pulse is raised. The code is straight binary for a single-ended input and two's complement for a differential input. The differential code comes from an offset-binary search with its top bit inverted.

Before the first conversion, the result register reads as the mid-scale pattern 0x80. When the output is switched off, the block flags the DAC output as released. It does not do so while a conversion is using the DAC.

Top module: `sar_dac_share_ctrl`

## Requirements
- R1: After reset the block has the following state: `result` = 0x80; `done`, `trackEn`, `holdEn` and `bufHold` are 0; `dacCode` follows `dacReg`.
- R2: A `startPulse` sampled high while idle opens a conversion. `trackEn` is high for the next TRACK_CYCLES cycles. `holdEn` is then high for the WIDTH cycles after that. The two are never high together.
- R3: The search starts at the most significant bit. In the first compare cycle `dacCode` is 0x80. On each compare step the trial bit is kept when `cmpHigh` is 1 and cleared when it is 0. `cmpHigh` = 1 means the held input is at or above the trial code.
- R4: With `diffMode` = 0, `result` is the straight-binary search outcome. A level of 0x00 gives 0x00 and a level of 0xFF gives 0xFF.
- R5: With `diffMode` = 1, `result` is the search outcome with bit 7 inverted. This is the two's complement of a signed input in the range -128..+127: an offset level of 0x80 gives 0x00, 0x00 gives 0x80 (-128), and 0xFF gives 0x7F (+127).
- R6: `done` is high for exactly one cycle. It rises on the TRACK_CYCLES+WIDTH-th clock edge after the edge that accepted the start, which is 10 edges with the defaults and well inside 90 µs at a 0.75 MHz clock. `result` carries the new code in that same cycle and holds it until the next conversion ends.
- R7: `bufHold` is high for the whole track and compare span and is low again in the `done` cycle. From that cycle on, `dacCode` equals `dacReg`.
- R8: A `startPulse` that arrives while a conversion is running is ignored. The running conversion keeps its timing and result, and no extra `done` pulse follows.
- R9: `dacRelease` is 1 only when `outEnable` is 0 and no conversion is running. It is 0 throughout a conversion.
- R10: `diffMode` is captured with the start strobe. A change to it during a conversion does not alter the coding of that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to convert |
| cmpHigh | input | 1 | Comparator decision: held input is at or above the DAC level |
| diffMode | input | 1 | 1 selects differential (two's complement) coding |
| outEnable | input | 1 | Analog output enable setting |
| dacReg | input | 8 | Output data register value for the DAC |
| dacCode | output | 8 | Code driven to the shared DAC |
| trackEn | output | 1 | Input sample-and-hold tracking |
| holdEn | output | 1 | Input sample held while comparing |
| bufHold | output | 1 | Freeze the analog output buffer |
| dacRelease | output | 1 | DAC output released (high-impedance indication) |
| result | output | 8 | Last conversion result |
| done | output | 1 | One-cycle conversion-complete pulse |

## Verification
The assertions assume that reset is applied before the first start. They also assume that `cmpHigh` is a settled function of the `dacCode` driven in the same cycle. The bench meets both conditions. It holds reset over the first edges. It models the comparator combinationally from `dacCode` and a held integer level, and it changes that level only while the block is idle. The start strobe is always driven away from the clock edge. Random levels, coding modes and output settings are mixed with directed full-scale, zero and mid-scale codes, and with mid-conversion start and mode changes.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } sarState_t;

  typedef struct packed {
    logic load;    // begin conversion: clear accumulator, capture coding
    logic step;    // one compare step this cycle
    logic finish;  // last compare step: write result
  } sarStrb_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int TRACK_CYCLES = 2,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int TW = $clog2(TRACK_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startPulse,
  output sarStrb_t      strb,
  output logic [IW-1:0] bitIdx,
  output logic          trackEn,
  output logic          holdEn,
  output logic          busy,
  output logic          done
);
  sarState_t     state;
  logic [TW-1:0] trackCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      trackCnt <= '0;
      bitIdx   <= IW'(WIDTH - 1);
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state    <= ST_TRACK;
            trackCnt <= '0;
          end
        end
        ST_TRACK: begin
          if (trackCnt == TW'(TRACK_CYCLES - 1)) begin
            state  <= ST_CONV;
            bitIdx <= IW'(WIDTH - 1);
          end else begin
            trackCnt <= trackCnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (bitIdx == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    trackEn     = (state == ST_TRACK);
    holdEn      = (state == ST_CONV);
    busy        = (state != ST_IDLE);
    strb.load   = (state == ST_IDLE) && startPulse;
    strb.step   = (state == ST_CONV);
    strb.finish = (state == ST_CONV) && (bitIdx == '0);
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trackEn |-> !holdEn);

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holdEn && bitIdx != '0) |=> (holdEn && bitIdx == $past(bitIdx) - 1'b1));

  // R7
  hold_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trackEn && startPulse && trackCnt != TW'(TRACK_CYCLES - 1)) |=> trackEn);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sarStrb_t         strb,
  input  logic [IW-1:0]    bitIdx,
  input  logic             busy,
  input  logic             cmpHigh,
  input  logic             diffMode,
  input  logic             outEnable,
  input  logic [WIDTH-1:0] dacReg,
  output logic [WIDTH-1:0] dacCode,
  output logic             dacRelease,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] trial;
  logic [WIDTH-1:0] nextAcc;
  logic             diffLatched;

  always_comb begin
    bitMask    = {{(WIDTH-1){1'b0}}, 1'b1} << bitIdx;
    trial      = acc | bitMask;
    nextAcc    = cmpHigh ? trial : acc;
    dacCode    = strb.step ? trial : dacReg;
    dacRelease = !outEnable && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      diffLatched <= 1'b0;
      result      <= MID_CODE;
    end else begin
      if (strb.load) begin
        acc         <= '0;
        diffLatched <= diffMode;
      end else if (strb.step) begin
        acc <= nextAcc;
      end
      if (strb.finish) begin
        result <= diffLatched ? (nextAcc ^ MID_CODE) : nextAcc;
      end
    end
  end

  // R3
  acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> (acc >= $past(acc)));

  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dacRelease |-> !busy);

  // R10
  coding_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strb.load) |=> $stable(diffLatched));
endmodule

// File: rtl/sar_dac_share_ctrl.sv
module sar_dac_share_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int TRACK_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic             cmpHigh,
  input  logic             diffMode,
  input  logic             outEnable,
  input  logic [WIDTH-1:0] dacReg,
  output logic [WIDTH-1:0] dacCode,
  output logic             trackEn,
  output logic             holdEn,
  output logic             bufHold,
  output logic             dacRelease,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sarStrb_t      strb;
  logic [IW-1:0] bitIdx;
  logic          busy;

  sar_ctrl #(.WIDTH(WIDTH), .TRACK_CYCLES(TRACK_CYCLES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .strb       (strb),
    .bitIdx     (bitIdx),
    .trackEn    (trackEn),
    .holdEn     (holdEn),
    .busy       (busy),
    .done       (done)
  );

  sar_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .bitIdx     (bitIdx),
    .busy       (busy),
    .cmpHigh    (cmpHigh),
    .diffMode   (diffMode),
    .outEnable  (outEnable),
    .dacReg     (dacReg),
    .dacCode    (dacCode),
    .dacRelease (dacRelease),
    .result     (result)
  );

  assign bufHold = busy;
endmodule

// File: tb/sar_dac_share_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_dac_share_ctrl_tb_top;
  localparam int T = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startPulse = 1'b0;
  logic diffMode = 1'b0;
  logic outEnable = 1'b0;
  logic [7:0] dacReg = 8'h00;
  logic [7:0] anaLevel = 8'h00;
  logic cmpHigh;
  logic [7:0] dacCode, result;
  logic trackEn, holdEn, bufHold, dacRelease, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // comparator model: held level at or above the DAC trial level
  assign cmpHigh = (anaLevel >= dacCode);

  sar_dac_share_ctrl #(.WIDTH(W), .TRACK_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .cmpHigh(cmpHigh),
    .diffMode(diffMode), .outEnable(outEnable), .dacReg(dacReg),
    .dacCode(dacCode), .trackEn(trackEn), .holdEn(holdEn), .bufHold(bufHold),
    .dacRelease(dacRelease), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_code(input int value, input bit diff);
    logic [7:0] r;
    r = diff ? 8'(value) : 8'(value);
    return r;
  endfunction

  // value: 0..255 single-ended, -128..127 differential
  task automatic run_conv(input int value, input bit diff, input bit oe,
                          input logic [7:0] regVal, input bit poke);
    logic [7:0] expRes;
    int phaseBad = 0;
    int relBad = 0;
    expRes = expect_code(value, diff);
    @(negedge clk);
    anaLevel   = diff ? 8'(value + 128) : 8'(value);
    diffMode   = diff;
    outEnable  = oe;
    dacReg     = regVal;
    startPulse = 1'b1;
    #1;
    check(dacRelease == !oe, "R9 idle release", dacRelease, !oe);
    for (int n = 1; n <= T + W + 1; n++) begin
      @(negedge clk);
      startPulse = poke && (n == 3);
      if (poke && n >= 3) diffMode = !diff;
      if (n <= T + W) begin
        if (trackEn != (n <= T) || holdEn != (n > T) || bufHold != 1'b1 || done)
          phaseBad++;
        if (dacRelease) relBad++;
      end
      if (n == T + 1)
        check(dacCode == 8'h80, "R3 first trial", dacCode, 8'h80);
      if (n == T + W + 1) begin
        check(done == 1'b1, "R6 done latency", done, 1);
        check(result == expRes, diff ? "R5 diff result" : "R4 single result",
              result, expRes);
        check(bufHold == 1'b0 && dacCode == regVal, "R7 dac returned",
              dacCode, regVal);
        check(dacRelease == !oe, "R9 release after", dacRelease, !oe);
      end
    end
    check(phaseBad == 0, "R2 phase sequence", phaseBad, 0);
    check(relBad == 0, "R9 busy release", relBad, 0);
    @(negedge clk);
    startPulse = 1'b0;
    diffMode   = diff;
    check(done == 1'b0 && result == expRes, "R6 done single pulse", done, 0);
    if (poke) begin
      bit extra = 1'b0;
      for (int k = 0; k < T + W + 3; k++) begin
        @(negedge clk);
        if (done || bufHold) extra = 1'b1;
      end
      check(extra == 1'b0, "R8 late start ignored", extra, 0);
      check(result == expRes, "R10 coding latched", result, expRes);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(result == 8'h80, "R1 reset result", result, 8'h80);
    check(!done && !trackEn && !holdEn && !bufHold, "R1 reset controls",
          {done, trackEn, holdEn, bufHold}, 0);
    rst_n = 1'b1;
    dacReg = 8'h5A;
    @(negedge clk);
    check(dacCode == 8'h5A, "R1 idle dac follows reg", dacCode, 8'h5A);
    // directed corners
    run_conv(8'h00, 1'b0, 1'b0, 8'h11, 1'b0);
    run_conv(8'hFF, 1'b0, 1'b1, 8'h22, 1'b0);
    run_conv(8'h80, 1'b0, 1'b1, 8'h33, 1'b0);
    run_conv(8'h7F, 1'b0, 1'b0, 8'h44, 1'b0);
    run_conv(-128, 1'b1, 1'b0, 8'h55, 1'b0);
    run_conv(127, 1'b1, 1'b1, 8'h66, 1'b0);
    run_conv(0, 1'b1, 1'b0, 8'h77, 1'b0);
    run_conv(-1, 1'b1, 1'b1, 8'h88, 1'b0);
    run_conv(8'hA5, 1'b0, 1'b1, 8'h99, 1'b1);
    run_conv(-37, 1'b1, 1'b0, 8'hAA, 1'b1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      bit d = 1'($urandom);
      int v = d ? (int'($urandom % 256) - 128) : int'($urandom % 256);
      run_conv(v, d, 1'($urandom), 8'($urandom), (i % 7) == 3);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule